// File: doc/BRIEF.md
# Reset Cause Recorder With Deferrable Warm Reset

This block gathers system reset requests from a set of warm sources (external pin, debug port, low-power handshake timeout, watchdog, software and core lockup) and from fatal sources. It drives the system reset for a fixed number of clock cycles and keeps three records of what happened: the cause of the latest reset, a sticky accumulation of every cause since the last cold reset, and a saturating count of completed reset sequences.

A warm source whose interrupt enable is set does not reset the system at once. Its pending flag is set, the interrupt output rises, and a timer counts 258 ticks of the slow clock enable. Software can use that window to shut down cleanly, or it can abort the reset: it removes the request at the source and then clears the flag by writing one to it. If any flag is still set when the timer expires, the reset proceeds. Fatal sources, and warm sources with the enable clear, reset at once.

A small write port reaches the interrupt enables, the flag-clear strobes and the sticky-clear strobes. All records are presented as output ports.

Top module: `reset_recorder`

## Requirements
- R1: After cold reset (`coldRstN` low), `sysRst`, `irq`, `irqEnable`, `pendFlags`, `lastStatus`, `stickyStatus` and `resetCount` are all zero.
- R2: A fatal request, or a warm request whose enable bit is clear, raises `sysRst` in the cycle after it is sampled. `sysRst` then stays high for exactly RST_HOLD cycles (default 4).
- R3: A warm request whose enable bit is set sets its bit in `pendFlags` on the next edge, and `irq` is the OR of `pendFlags`. A shared timer counts `slowTick` pulses while any flag is set and clears when none is set. `sysRst` rises on the edge that samples the DEFER_TICKS-th pulse (default 258).
- R4: If the request is removed and its flag is cleared before the timer expires, no reset happens and `irq` falls. A flag that is cleared while its request is still present sets again on the next edge.
- R5: `lastStatus` is rewritten when each reset starts. Bit 0 marks the warm class, and bit 1 marks the fatal class, which wins when any fatal source is present. Bits 2..7 hold the warm sources in the order pin, debug, low-power timeout, watchdog, software, lockup. Bits 8..9 hold the fatal sources. All sources that coincide are recorded together. On expiry, the flags still set are recorded.
- R6: `stickyStatus` ORs in each recorded word. A bit falls only when a one is written to it with selector 2. If a set and a clear land in the same cycle, the set wins.
- R7: `resetCount` increases by one in the cycle a reset sequence ends, and it holds at 255.
- R8: While `sysRst` is high, every request is ignored and all pending flags are held at zero.
- R9: Write selectors: 0 loads `irqEnable` from `wrData[5:0]`, 1 clears the flags at the ones in `wrData[5:0]`, 2 clears the sticky bits at the ones in `wrData[9:0]`, and 3 has no effect.
- R10: A reset sequence keeps `stickyStatus`, `resetCount` and `irqEnable`. Only a cold reset clears them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| coldRstN | input | 1 | Asynchronous cold reset, active low |
| slowTick | input | 1 | One-cycle enable at the slow clock rate |
| warmReq | input | 6 | Warm reset requests (pin, debug, lp-timeout, watchdog, software, lockup) |
| fatalReq | input | 2 | Fatal reset requests |
| wrEn | input | 1 | Write strobe |
| wrSel | input | 2 | Write target selector |
| wrData | input | 10 | Write data |
| sysRst | output | 1 | System reset output |
| irq | output | 1 | Reset-pending interrupt |
| irqEnable | output | 6 | Per-source deferral enables |
| pendFlags | output | 6 | Per-source pending flags |
| lastStatus | output | 10 | Cause of the most recent reset |
| stickyStatus | output | 10 | Causes accumulated since cold reset |
| resetCount | output | 8 | Completed reset sequences, saturating |

## Verification
An immediate request shows on `sysRst` one edge after it is sampled, and `lastStatus` and `stickyStatus` change on that same edge. `resetCount` moves on the edge that ends the RST_HOLD-cycle sequence. A deferred request shows on `pendFlags` and `irq` one edge after it is sampled, and on `sysRst` at the edge that samples the 258th `slowTick` pulse. The reference model advances on each rising edge from the inputs that edge samples, and the comparison runs a fixed delay after that edge, so every result is observed in the cycle it is due. Directed checks sample at the falling edge, once the sequences they depend on have settled.

// File: rtl/rrec_pkg.sv
package rrec_pkg;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_HOLD = 1'b1
  } seqState_e;

  // control -> datapath strobes
  typedef struct packed {
    logic capture;  // a reset starts this edge: record the cause word
    logic expire;   // deferral ran out: still-set flags join the word
    logic clrPend;  // hold every pending flag at zero
    logic finish;   // last cycle of the reset sequence
  } strobe_t;

  localparam logic [1:0] SEL_ENABLE    = 2'd0;
  localparam logic [1:0] SEL_FLAGCLR   = 2'd1;
  localparam logic [1:0] SEL_STICKYCLR = 2'd2;

  localparam int CLASS_WARM  = 0;
  localparam int CLASS_FATAL = 1;
  localparam int SRC_BASE    = 2;

endpackage

// File: rtl/rrec_ctrl.sv
module rrec_ctrl
  import rrec_pkg::*;
#(
  parameter int DEFER_TICKS = 258,
  parameter int RST_HOLD    = 4
) (
  input  logic    clk,
  input  logic    coldRstN,
  input  logic    slowTick,
  input  logic    immHit,
  input  logic    anyFlag,
  output strobe_t strobe,
  output logic    sysRst
);
  localparam int TW = $clog2(DEFER_TICKS + 1);
  localparam int HW = $clog2(RST_HOLD + 1);

  seqState_e stateQ;
  logic [TW-1:0] timerQ;
  logic [HW-1:0] holdQ;
  logic lastTick;

  assign lastTick = anyFlag && slowTick && (timerQ == TW'(DEFER_TICKS - 1));

  always_comb begin
    strobe = '0;
    if (stateQ == ST_IDLE) begin
      strobe.expire  = lastTick;
      strobe.capture = immHit || lastTick;
    end
    strobe.clrPend = (stateQ == ST_HOLD) || strobe.capture;
    strobe.finish  = (stateQ == ST_HOLD) && (holdQ == HW'(RST_HOLD - 1));
  end

  always_ff @(posedge clk or negedge coldRstN) begin
    if (!coldRstN) begin
      stateQ <= ST_IDLE;
      timerQ <= '0;
      holdQ  <= '0;
    end else if (stateQ == ST_IDLE) begin
      if (strobe.capture) begin
        stateQ <= ST_HOLD;
        holdQ  <= '0;
        timerQ <= '0;
      end else if (!anyFlag) begin
        timerQ <= '0;
      end else if (slowTick) begin
        timerQ <= timerQ + 1'b1;
      end
    end else begin
      timerQ <= '0;
      if (strobe.finish) begin
        stateQ <= ST_IDLE;
      end else begin
        holdQ <= holdQ + 1'b1;
      end
    end
  end

  assign sysRst = (stateQ == ST_HOLD);

  // R2: a start strobe always leads to reset on the next edge
  a_r2_capture_asserts: assert property (@(posedge clk) disable iff (!coldRstN)
    strobe.capture |=> sysRst);

  // R3: deferral timer never passes its limit
  a_r3_timer_bound: assert property (@(posedge clk) disable iff (!coldRstN)
    timerQ < TW'(DEFER_TICKS));

endmodule

// File: rtl/rrec_data.sv
module rrec_data
  import rrec_pkg::*;
#(
  parameter int N_WARM  = 6,
  parameter int N_FATAL = 2,
  parameter int CNT_W   = 8,
  localparam int SW     = SRC_BASE + N_WARM + N_FATAL
) (
  input  logic               clk,
  input  logic               coldRstN,
  input  logic [N_WARM-1:0]  warmReq,
  input  logic [N_FATAL-1:0] fatalReq,
  input  logic               wrEn,
  input  logic [1:0]         wrSel,
  input  logic [SW-1:0]      wrData,
  input  strobe_t            strobe,
  output logic               immHit,
  output logic               anyFlag,
  output logic [N_WARM-1:0]  irqEnable,
  output logic [N_WARM-1:0]  pendFlags,
  output logic [SW-1:0]      lastStatus,
  output logic [SW-1:0]      stickyStatus,
  output logic [CNT_W-1:0]   resetCount
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [N_WARM-1:0] enQ, flagQ, flagClr, warmHit;
  logic [SW-1:0]     lastQ, stickyQ, stickyClr, causeWord;
  logic [CNT_W-1:0]  cntQ;

  assign flagClr   = (wrEn && wrSel == SEL_FLAGCLR) ? wrData[N_WARM-1:0] : '0;
  assign stickyClr = (wrEn && wrSel == SEL_STICKYCLR) ? wrData : '0;

  assign immHit  = (|fatalReq) || (|(warmReq & ~enQ));
  assign anyFlag = |flagQ;
  assign warmHit = (warmReq & ~enQ) | (strobe.expire ? flagQ : '0);

  always_comb begin
    causeWord = '0;
    causeWord[CLASS_FATAL] = |fatalReq;
    causeWord[CLASS_WARM]  = ~(|fatalReq);
    causeWord[SRC_BASE +: N_WARM] = warmHit;
    causeWord[SRC_BASE + N_WARM +: N_FATAL] = fatalReq;
  end

  always_ff @(posedge clk or negedge coldRstN) begin
    if (!coldRstN) begin
      enQ <= '0;
    end else if (wrEn && wrSel == SEL_ENABLE) begin
      enQ <= wrData[N_WARM-1:0];
    end
  end

  // one pending flag per warm source
  for (genvar i = 0; i < N_WARM; i++) begin : g_flag
    always_ff @(posedge clk or negedge coldRstN) begin
      if (!coldRstN) begin
        flagQ[i] <= 1'b0;
      end else if (strobe.clrPend) begin
        flagQ[i] <= 1'b0;
      end else if (warmReq[i] && enQ[i]) begin
        flagQ[i] <= 1'b1;
      end else if (flagClr[i]) begin
        flagQ[i] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge coldRstN) begin
    if (!coldRstN) begin
      lastQ   <= '0;
      stickyQ <= '0;
    end else if (strobe.capture) begin
      lastQ   <= causeWord;
      stickyQ <= (stickyQ & ~stickyClr) | causeWord;
    end else begin
      stickyQ <= stickyQ & ~stickyClr;
    end
  end

  always_ff @(posedge clk or negedge coldRstN) begin
    if (!coldRstN) begin
      cntQ <= '0;
    end else if (strobe.finish && cntQ != CNT_MAX) begin
      cntQ <= cntQ + 1'b1;
    end
  end

  assign irqEnable    = enQ;
  assign pendFlags    = flagQ;
  assign lastStatus   = lastQ;
  assign stickyStatus = stickyQ;
  assign resetCount   = cntQ;

  // R6: sticky bits only fall under a clear write
  a_r6_sticky_keep: assert property (@(posedge clk) disable iff (!coldRstN)
    !(wrEn && wrSel == SEL_STICKYCLR) |=> ((stickyQ & $past(stickyQ)) == $past(stickyQ)));

  // R7: counter steps by at most one and never wraps
  a_r7_count_step: assert property (@(posedge clk) disable iff (!coldRstN)
    1'b1 |=> (cntQ == $past(cntQ)) || (cntQ == $past(cntQ) + 1'b1));
  a_r7_count_sat: assert property (@(posedge clk) disable iff (!coldRstN)
    (cntQ == CNT_MAX) |=> (cntQ == CNT_MAX));

  // R5: a recorded word carries exactly one class bit
  a_r5_class_onehot: assert property (@(posedge clk) disable iff (!coldRstN)
    (lastQ != '0) |-> ($countones(lastQ[1:0]) == 1));

endmodule

// File: rtl/reset_recorder.sv
module reset_recorder
  import rrec_pkg::*;
#(
  parameter int N_WARM      = 6,
  parameter int N_FATAL     = 2,
  parameter int CNT_W       = 8,
  parameter int DEFER_TICKS = 258,
  parameter int RST_HOLD    = 4,
  localparam int SW         = SRC_BASE + N_WARM + N_FATAL
) (
  input  logic               clk,
  input  logic               coldRstN,
  input  logic               slowTick,
  input  logic [N_WARM-1:0]  warmReq,
  input  logic [N_FATAL-1:0] fatalReq,
  input  logic               wrEn,
  input  logic [1:0]         wrSel,
  input  logic [SW-1:0]      wrData,
  output logic               sysRst,
  output logic               irq,
  output logic [N_WARM-1:0]  irqEnable,
  output logic [N_WARM-1:0]  pendFlags,
  output logic [SW-1:0]      lastStatus,
  output logic [SW-1:0]      stickyStatus,
  output logic [CNT_W-1:0]   resetCount
);
  strobe_t strobe;
  logic    immHit, anyFlag;

  rrec_ctrl #(.DEFER_TICKS(DEFER_TICKS), .RST_HOLD(RST_HOLD)) u_ctrl (
    .clk(clk), .coldRstN(coldRstN), .slowTick(slowTick),
    .immHit(immHit), .anyFlag(anyFlag), .strobe(strobe), .sysRst(sysRst)
  );

  rrec_data #(.N_WARM(N_WARM), .N_FATAL(N_FATAL), .CNT_W(CNT_W)) u_data (
    .clk(clk), .coldRstN(coldRstN), .warmReq(warmReq), .fatalReq(fatalReq),
    .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData), .strobe(strobe),
    .immHit(immHit), .anyFlag(anyFlag), .irqEnable(irqEnable),
    .pendFlags(pendFlags), .lastStatus(lastStatus),
    .stickyStatus(stickyStatus), .resetCount(resetCount)
  );

  assign irq = anyFlag;

  // R8: no pending interrupt while the system is held in reset
  a_r8_no_irq_in_reset: assert property (@(posedge clk) disable iff (!coldRstN)
    sysRst |-> !irq);

endmodule

// File: tb/reset_recorder_test.sv
module reset_recorder_test;
  localparam int CLK_PERIOD = 10;
  localparam int DEFER = 258;
  localparam int HOLD  = 4;

  logic clk = 0, coldRstN = 0, slowTick = 0, wrEn = 0;
  logic [5:0] warmReq = 0;
  logic [1:0] fatalReq = 0, wrSel = 0;
  logic [9:0] wrData = 0;
  logic sysRst, irq;
  logic [5:0] irqEnable, pendFlags;
  logic [9:0] lastStatus, stickyStatus;
  logic [7:0] resetCount;

  int vecs = 0, errs = 0;
  bit done = 0;

  reset_recorder uut (
    .clk(clk), .coldRstN(coldRstN), .slowTick(slowTick), .warmReq(warmReq),
    .fatalReq(fatalReq), .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .sysRst(sysRst), .irq(irq), .irqEnable(irqEnable), .pendFlags(pendFlags),
    .lastStatus(lastStatus), .stickyStatus(stickyStatus), .resetCount(resetCount)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference model
  bit mInHold; int mHold, mTimer, mCnt;
  logic [5:0] mEn, mFlags; logic [9:0] mLast, mSticky;

  always @(posedge clk) begin
    logic [5:0] fclr, warmHit; logic [9:0] sclr, word; bit lastTick, cap;
    if (!coldRstN) begin
      mInHold = 0; mHold = 0; mTimer = 0; mCnt = 0;
      mEn = 0; mFlags = 0; mLast = 0; mSticky = 0;
    end else begin
      fclr = (wrEn && wrSel == 2'd1) ? wrData[5:0] : 6'd0;
      sclr = (wrEn && wrSel == 2'd2) ? wrData : 10'd0;
      if (!mInHold) begin
        lastTick = (mFlags != 0) && slowTick && (mTimer == DEFER - 1);
        cap = (fatalReq != 0) || ((warmReq & ~mEn) != 0) || lastTick;
        if (cap) begin
          warmHit = (warmReq & ~mEn) | (lastTick ? mFlags : 6'd0);
          word = {fatalReq, warmHit, (fatalReq != 0), (fatalReq == 0)};
          mLast = word; mSticky = (mSticky & ~sclr) | word;
          mInHold = 1; mHold = 0; mTimer = 0; mFlags = 0;
        end else begin
          if (mFlags == 0) mTimer = 0; else if (slowTick) mTimer++;
          mFlags = (mFlags & ~fclr) | (warmReq & mEn);
          mSticky = mSticky & ~sclr;
        end
      end else begin
        mFlags = 0; mTimer = 0; mSticky = mSticky & ~sclr;
        if (mHold == HOLD - 1) begin
          mInHold = 0; if (mCnt < 255) mCnt++;
        end else mHold++;
      end
      if (wrEn && wrSel == 2'd0) mEn = wrData[5:0];
    end
    #1;
    chk("R2 sysRst", sysRst, mInHold);
    chk("R3 irq", irq, mFlags != 0);
    chk("R3 pendFlags", pendFlags, mFlags);
    chk("R9 irqEnable", irqEnable, mEn);
    chk("R5 lastStatus", lastStatus, mLast);
    chk("R6 stickyStatus", stickyStatus, mSticky);
    chk("R7 resetCount", resetCount, mCnt);
  end

  // slow tick: one cycle in four
  initial begin
    int c = 0;
    forever begin
      @(negedge clk);
      slowTick = (c % 4 == 3);
      c++;
    end
  end

  task automatic wr(input logic [1:0] sel, input logic [9:0] d);
    @(negedge clk); wrEn = 1; wrSel = sel; wrData = d;
    @(negedge clk); wrEn = 0; wrData = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errs++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    int waited;
    idle(3); coldRstN = 1; idle(1);
    // R1 reset state
    chk("R1 reset sysRst", sysRst, 0);
    chk("R1 reset status", {lastStatus, stickyStatus, resetCount}, 0);

    // R2 fatal source immediate
    @(negedge clk); fatalReq = 2'b01;
    @(negedge clk); fatalReq = 0;
    chk("R2 sysRst raised", sysRst, 1);
    idle(HOLD + 2);
    chk("R5 fatal word", lastStatus, 10'h102);
    chk("R7 count one", resetCount, 1);

    // R2 warm software source with enable clear
    @(negedge clk); warmReq = 6'b010000;
    @(negedge clk); warmReq = 0;
    idle(HOLD + 2);
    chk("R5 warm word", lastStatus, 10'h041);

    // R8 request during hold ignored
    @(negedge clk); fatalReq = 2'b10;
    @(negedge clk); fatalReq = 0; warmReq = 6'b000001;
    @(negedge clk); warmReq = 0;
    idle(HOLD + 2);
    chk("R8 pin ignored in hold", stickyStatus[2], 0);
    chk("R10 count kept", resetCount, 3);

    // R3 deferred watchdog
    wr(2'd0, 10'b001000);
    @(negedge clk); warmReq = 6'b001000;
    idle(2);
    chk("R3 irq raised", irq, 1);
    idle(800);
    chk("R3 no early reset", sysRst, 0);
    waited = 0;
    while (!sysRst && waited < 2000) begin @(negedge clk); waited++; end
    warmReq = 0;
    chk("R3 deferred reset", sysRst, 1);
    idle(HOLD + 2);
    chk("R5 deferred word", lastStatus, 10'h021);
    chk("R10 enable kept", irqEnable, 6'b001000);

    // R4 abort: remove then clear flag
    wr(2'd0, 10'b000001);
    @(negedge clk); warmReq = 6'b000001;
    idle(100);
    warmReq = 0;
    wr(2'd1, 10'b000001);
    idle(2);
    chk("R4 irq dropped", irq, 0);
    idle(1200);
    chk("R4 no reset", resetCount, 4);
    // R4 clear while request present re-arms
    @(negedge clk); warmReq = 6'b000001;
    idle(2);
    wr(2'd1, 10'b000001);
    idle(1);
    chk("R4 flag re-sets", pendFlags, 6'b000001);
    warmReq = 0;
    wr(2'd1, 10'b000001);
    idle(2);

    // R6 sticky clear of one bit; R9 selector 3 no effect
    wr(2'd3, 10'h3ff);
    chk("R9 sel3 no effect", stickyStatus, 10'h363);
    wr(2'd2, 10'h020);
    chk("R6 sticky w1c", stickyStatus, 10'h343);

    // R7 saturation
    for (int i = 0; i < 260; i++) begin
      @(negedge clk); fatalReq = 2'b10;
      @(negedge clk); fatalReq = 0;
      idle(HOLD);
    end
    chk("R7 saturated", resetCount, 255);

    // R10 cold reset clears records
    @(negedge clk); coldRstN = 0;
    idle(2); coldRstN = 1; idle(1);
    chk("R10 cold clears", {stickyStatus, resetCount, irqEnable}, 0);
    idle(3);
    finishRun();
  end
endmodule